// File: doc/BRIEF.md
# PCI-to-ISA interrupt routing matrix

This block steers four level-sensitive PCI interrupt lines onto a sixteen-line ISA interrupt bus. Each PCI line owns one byte-wide routing register. When the register holds a number below sixteen, that number picks the ISA line that the PCI line drives. Any larger value leaves the PCI line unconnected. Several PCI lines may pick the same ISA line, and that ISA line then carries the OR of their levels.

Software programs the routes through a small byte-addressed port that stands in for configuration-space access. The routing registers sit at offsets 0x60 to 0x63. The ISA outputs are combinational in the PCI levels and the stored routes. A change on a PCI line therefore shows on the ISA bus in the same cycle. A new route takes effect at the clock edge that captures the write.

Top module: `irq_route_matrix`

## Requirements
- R1: The routing registers for PCI lines A, B, C and D are at offsets 0x60, 0x61, 0x62 and 0x63, in that order. Port bit 0 of `pirq_lvl` is line A and bit 3 is line D.
- R2: While `rst_n` is low, all four routing registers hold 0x80 and every bit of `isa_irq` is low, whatever the PCI levels are. After reset is released, every routing register reads back 0x80.
- R3: A routing value V in 0..15 drives `isa_irq[V]` with the line's level. A change of the PCI level appears on `isa_irq` in the same cycle.
- R4: A routing value of 16 or more leaves its PCI line without effect on any ISA output. Examples are 0x10, 0x80, 0x9A and 0xFF.
- R5: When several PCI lines select the same ISA line, that ISA line is the OR of their levels.
- R6: A write stores all eight bits of `cfg_wdata`, and a later read of the same offset returns them unchanged.
- R7: A read outside 0x60..0x63 returns 0x00, and a write outside that range changes no routing register. When `cfg_re` is low, `cfg_rdata` is 0x00.
- R8: If a route is rewritten while its PCI line is high, the old ISA line stays high until the write's clock edge. After that edge the old line drops, unless another high line still maps to it, and the new ISA line rises.
- R9: An ISA line that no high PCI line selects is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| pirq_lvl | input | 4 | PCI interrupt levels, bit 0 is line A |
| cfg_addr | input | 8 | Register port byte offset |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write strobe, captured at the rising clock edge |
| cfg_re | input | 1 | Read enable; the read data is combinational |
| cfg_rdata | output | 8 | Read data |
| isa_irq | output | 16 | ISA interrupt levels |

## Verification
A wrong route byte shows up on the ISA bus as soon as the PCI line it governs goes high, and in the same cycle, because the outputs carry no register stage. A wrong route byte with its line low shows nothing on the bus, so the bench also reads back every route byte, and the read data exposes any wrong bit in the same cycle. Because every bit is compared with a model on every clock, a lost OR term or a wrongly decoded out-of-range value is caught during the first PCI pattern that exercises it.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned PIRQ_COUNT = 4;
  localparam int unsigned ISA_COUNT = 16;
  localparam int unsigned CFG_AW = 8;
  localparam int unsigned CFG_DW = 8;
  localparam logic [CFG_AW-1:0] ROUTE_BASE = 8'h60;
  localparam logic [CFG_DW-1:0] ROUTE_RESET = 8'h80;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign srst_n = chain_q[STAGES-1] & arst_n;
endmodule

// File: rtl/irq_route_regfile.sv
module irq_route_regfile #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8,
  parameter logic [AW-1:0] BASE = 8'h60,
  parameter logic [DW-1:0] RESET_VAL = 8'h80
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cfg_we,
  input  logic                           cfg_re,
  input  logic [AW-1:0]                  cfg_addr,
  input  logic [DW-1:0]                  cfg_wdata,
  output logic [DW-1:0]                  cfg_rdata,
  output logic [NUM_LINES-1:0][DW-1:0]   route_q
);
  localparam logic [AW:0] END_ADDR = {1'b0, BASE} + (AW+1)'(NUM_LINES);

  logic [AW-1:0]        offset;
  logic                 in_window;
  logic [NUM_LINES-1:0] wr_en;
  logic [NUM_LINES-1:0][DW-1:0] route_d;

  always_comb begin
    offset    = cfg_addr - BASE;
    in_window = (cfg_addr >= BASE) && ({1'b0, cfg_addr} < END_ADDR);
  end

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_route
    always_comb begin
      wr_en[i]   = cfg_we && in_window && (offset == AW'(i));
      route_d[i] = wr_en[i] ? cfg_wdata : route_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        route_q[i] <= RESET_VAL;
      end else if (wr_en[i]) begin
        route_q[i] <= route_d[i];
      end
    end

    // R6
    stored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && ({1'b0, cfg_addr} == ({1'b0, BASE} + (AW+1)'(i))))
      |=> (route_q[i] == $past(cfg_wdata)));
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_re && in_window) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (offset == AW'(i)) cfg_rdata = route_q[i];
      end
    end
  end

  // R7
  stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && ((cfg_addr < BASE) || ({1'b0, cfg_addr} >= END_ADDR)))
    |=> $stable(route_q));

  // R7
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_re |-> (cfg_rdata == '0));
endmodule

// File: rtl/irq_route_decoder.sv
module irq_route_decoder #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_OUT = 16,
  parameter int unsigned DW = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_LINES-1:0][DW-1:0]       route_q,
  output logic [NUM_LINES-1:0][NUM_OUT-1:0]  sel
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    always_comb begin
      sel[i] = '0;
      for (int j = 0; j < NUM_OUT; j++) begin
        if (route_q[i] == DW'(j)) sel[i][j] = 1'b1;
      end
    end

    // R3
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel[i]));

    // R4
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_q[i] >= DW'(NUM_OUT)) |-> (sel[i] == '0));
  end
endmodule

// File: rtl/irq_or_matrix.sv
module irq_or_matrix #(
  parameter int unsigned NUM_LINES = 4,
  parameter int unsigned NUM_OUT = 16
) (
  input  logic [NUM_LINES-1:0]               line_lvl,
  input  logic [NUM_LINES-1:0][NUM_OUT-1:0]  sel,
  output logic [NUM_OUT-1:0]                 irq_out
);
  for (genvar j = 0; j < NUM_OUT; j++) begin : g_out
    logic [NUM_LINES-1:0] term;
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_term
      assign term[i] = line_lvl[i] & sel[i][j];
    end
    assign irq_out[j] = |term;
  end
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix
  import irq_route_pkg::*;
#(
  parameter int unsigned NUM_PIRQ = PIRQ_COUNT,
  parameter int unsigned NUM_ISA = ISA_COUNT,
  parameter int unsigned AW = CFG_AW,
  parameter int unsigned DW = CFG_DW,
  parameter logic [CFG_AW-1:0] BASE = ROUTE_BASE,
  parameter logic [CFG_DW-1:0] RESET_VAL = ROUTE_RESET
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PIRQ-1:0] pirq_lvl,
  input  logic [AW-1:0]       cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  input  logic                cfg_we,
  input  logic                cfg_re,
  output logic [DW-1:0]       cfg_rdata,
  output logic [NUM_ISA-1:0]  isa_irq
);
  logic                              rst_n_sync;
  logic [NUM_PIRQ-1:0][DW-1:0]       route_q;
  logic [NUM_PIRQ-1:0][NUM_ISA-1:0]  sel;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_sync)
  );

  irq_route_regfile #(
    .NUM_LINES (NUM_PIRQ),
    .AW        (AW),
    .DW        (DW),
    .BASE      (BASE[AW-1:0]),
    .RESET_VAL (RESET_VAL[DW-1:0])
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .cfg_we    (cfg_we),
    .cfg_re    (cfg_re),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .route_q   (route_q)
  );

  irq_route_decoder #(
    .NUM_LINES (NUM_PIRQ),
    .NUM_OUT   (NUM_ISA),
    .DW        (DW)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .route_q (route_q),
    .sel     (sel)
  );

  irq_or_matrix #(
    .NUM_LINES (NUM_PIRQ),
    .NUM_OUT   (NUM_ISA)
  ) u_or (
    .line_lvl (pirq_lvl),
    .sel      (sel),
    .irq_out  (isa_irq)
  );

  // R9
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (pirq_lvl == '0) |-> (isa_irq == '0));

  // R3
  fanout_bound_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $countones(isa_irq) <= $countones(pirq_lvl));
endmodule

// File: tb/test_irq_route_matrix.sv
module test_irq_route_matrix;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [3:0]  pirq_lvl;
  logic [7:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        cfg_we;
  logic        cfg_re;
  logic [7:0]  cfg_rdata;
  logic [15:0] isa_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] m_route [4];

  irq_route_matrix i_irq_route_matrix (
    .clk       (clk),
    .rst_n     (rst_n),
    .pirq_lvl  (pirq_lvl),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_we    (cfg_we),
    .cfg_re    (cfg_re),
    .cfg_rdata (cfg_rdata),
    .isa_irq   (isa_irq)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  function automatic logic [15:0] model_isa(input logic [3:0] p);
    logic [15:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      if (p[i] && (m_route[i] < 8'd16)) r[m_route[i][3:0]] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic in_win(input logic [7:0] a);
    return (a >= 8'h60) && (a <= 8'h63);
  endfunction

  task automatic step(input logic [3:0] p, input logic we, input logic re,
                      input logic [7:0] a, input logic [7:0] d, input string req);
    logic [15:0] e_isa;
    logic [7:0]  e_rd;
    pirq_lvl = p; cfg_we = we; cfg_re = re; cfg_addr = a; cfg_wdata = d;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_route[i] = 8'h80;
    end
    #(CLK_PERIOD/2 - 1);
    e_isa = model_isa(p);
    e_rd  = (re && in_win(a)) ? m_route[a[1:0]] : 8'h00;
    checks++;
    if (isa_irq !== e_isa) begin
      errors++;
      $display("FAIL %s isa_irq actual=%h expected=%h", req, isa_irq, e_isa);
    end
    checks++;
    if (cfg_rdata !== e_rd) begin
      errors++;
      $display("FAIL %s cfg_rdata actual=%h expected=%h", req, cfg_rdata, e_rd);
    end
    @(posedge clk);
    if (rst_n && we && in_win(a)) m_route[a[1:0]] = d;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] p, input logic [7:0] a, input logic [7:0] d, input string req);
    step(p, 1'b1, 1'b0, a, d, req);
  endtask

  task automatic rd(input logic [3:0] p, input logic [7:0] a, input string req);
    step(p, 1'b0, 1'b1, a, 8'h00, req);
  endtask

  task automatic idle(input logic [3:0] p, input string req);
    step(p, 1'b0, 1'b0, 8'h00, 8'h00, req);
  endtask

  task automatic sweep(input string req);
    for (int k = 0; k < 16; k++) idle(4'(k), req);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not complete");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pirq_lvl = '0; cfg_addr = '0; cfg_wdata = '0; cfg_we = 1'b0; cfg_re = 1'b0;
    for (int i = 0; i < 4; i++) m_route[i] = 8'h80;
    @(negedge clk);
    // R2: all outputs low in reset with every PCI line high
    idle(4'hF, "R2");
    wr(4'hF, 8'h60, 8'h01, "R2");
    idle(4'hF, "R2");
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) idle(4'hF, "R2");
    // R1 R2: reset value read back at each routing offset
    for (int k = 0; k < 4; k++) rd(4'hF, 8'h60 + 8'(k), "R1");
    sweep("R4");
    // R3 R1: distinct routes per line
    wr(4'h0, 8'h60, 8'h05, "R3");
    wr(4'h1, 8'h61, 8'h0E, "R1");
    wr(4'h2, 8'h62, 8'h03, "R1");
    wr(4'h4, 8'h63, 8'h00, "R1");
    sweep("R3");
    wr(4'h8, 8'h63, 8'h0F, "R3");
    sweep("R9");
    // R5: shared destination
    wr(4'h3, 8'h61, 8'h05, "R5");
    wr(4'h3, 8'h62, 8'h05, "R5");
    sweep("R5");
    // R4 R6: out-of-range routes stored in full and ignored
    wr(4'hF, 8'h62, 8'h10, "R4");
    wr(4'hF, 8'h63, 8'hFF, "R4");
    rd(4'hF, 8'h63, "R6");
    wr(4'hF, 8'h61, 8'h9A, "R6");
    rd(4'hF, 8'h61, "R6");
    rd(4'hF, 8'h62, "R6");
    sweep("R4");
    wr(4'hF, 8'h60, 8'h80, "R4");
    sweep("R4");
    // R7: stray offsets
    wr(4'h0, 8'h60, 8'h07, "R7");
    wr(4'hF, 8'h5F, 8'h01, "R7");
    wr(4'hF, 8'h64, 8'h02, "R7");
    wr(4'hF, 8'h00, 8'h03, "R7");
    wr(4'hF, 8'hE0, 8'h04, "R7");
    rd(4'hF, 8'h5F, "R7");
    rd(4'hF, 8'h64, "R7");
    rd(4'hF, 8'hFF, "R7");
    for (int k = 0; k < 4; k++) rd(4'hF, 8'h60 + 8'(k), "R7");
    sweep("R7");
    // R8: reroute a live line
    wr(4'h0, 8'h61, 8'h80, "R8");
    wr(4'h1, 8'h60, 8'h02, "R8");
    idle(4'h1, "R8");
    wr(4'h1, 8'h60, 8'h09, "R8");
    idle(4'h1, "R8");
    wr(4'h3, 8'h61, 8'h09, "R8");
    wr(4'h3, 8'h60, 8'h0B, "R8");
    idle(4'h3, "R8");
    wr(4'h3, 8'h61, 8'h0B, "R8");
    idle(4'h3, "R8");
    // R2: reset during operation
    wr(4'hF, 8'h62, 8'h04, "R2");
    rst_n = 1'b0;
    idle(4'hF, "R2");
    idle(4'hF, "R2");
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) idle(4'hF, "R2");
    for (int k = 0; k < 4; k++) rd(4'hF, 8'h60 + 8'(k), "R2");
    summary();
    $finish;
  end
endmodule